// File: doc/BRIEF.md
# Smart Squelch Packet Qualifier

This block decides, one clock tick at a time, whether the signal on a twisted-pair receive line is real packet data or noise. Two comparator flags come in: one is high while the line is above the positive threshold, the other while it is below the negative threshold. Both are sampled on a 20 MHz clock, so one tick is 50 ns. Before data is accepted, the line has to cross the threshold of whichever polarity comes first. It then has to cross the opposite threshold within a short window, and cross the first polarity again within a second window of the same length. After that, the block raises a data-valid flag. It also drives a select line that switches the analog comparators to their lower threshold pair.

The flag stays high for as long as the line keeps crossing either threshold. The packet ends once the line has been quiet for longer than the end-of-packet window. At that point the block drops the flag, restores the normal thresholds and goes back to waiting for a new three-step sequence. A reduced-squelch mode input holds the lower thresholds selected from the start. The sequence rules are the same in that mode. The window lengths are parameters; both default to 3 ticks (150 ns).

Top module: `squelch_qualifier`

## Requirements
- R1: A lone crossing of either threshold that is not followed by the rest of the sequence never raises `data_valid_o`.
- R2: After the first crossing, the opposite threshold must be seen in one of the next WIN_TICKS sampled cycles. Otherwise the attempt is abandoned with no output, and the block is idle again after the WIN_TICKS-th cycle.
- R3: If the first polarity is seen again in one of the WIN_TICKS cycles after the opposite crossing, `data_valid_o` goes high. It is visible just after the clock edge that sampled that third crossing.
- R4: The sequence may start with either polarity. "Opposite" always means the polarity that was not crossed first. When both flags are high in the idle state, positive counts as the first polarity.
- R5: While data is valid, a crossing of either threshold restarts the quiet count. `data_valid_o` stays high through EOP_TICKS consecutive quiet samples and falls on the clock edge that samples the (EOP_TICKS+1)-th one.
- R6: `low_thresh_sel_o` is high whenever `data_valid_o` is high (1 = lower threshold pair).
- R7: While `reduced_mode_i` is 1, `low_thresh_sel_o` is 1 in every cycle. The sequence and end-of-packet timing are the same as in normal mode.
- R8: After end of packet, `low_thresh_sel_o` follows `reduced_mode_i` again, and a new full three-step sequence is needed before data is valid again.
- R9: During and just after reset, `data_valid_o` is 0 and `low_thresh_sel_o` equals `reduced_mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| above_pos_i | input | 1 | Comparator flag: line above the positive threshold |
| below_neg_i | input | 1 | Comparator flag: line below the negative threshold |
| reduced_mode_i | input | 1 | 1 selects the lower thresholds from the start |
| data_valid_o | output | 1 | Valid packet data present |
| low_thresh_sel_o | output | 1 | 1 selects the lower comparator threshold pair |

## Verification
Each comparator sample is taken at a clock edge, and `data_valid_o` reflects it immediately after that same edge. There is exactly one register between a sample and the flag. `low_thresh_sel_o` additionally follows `reduced_mode_i` with no register at all. The bench applies one sample per cycle a quarter period after the edge, and reads both outputs a quarter period after the next edge. Every expected value is indexed by the cycle of the stimulus that produced it: acceptance lands on the third crossing's own cycle, and the drop lands EOP_TICKS+1 quiet cycles after the last crossing.

// File: rtl/squelch_pkg.sv
package squelch_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE      = 2'd0,
        SQ_WAIT_OPP  = 2'd1,
        SQ_WAIT_BACK = 2'd2,
        SQ_VALID     = 2'd3
    } sq_state_e;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } sq_pol_e;

    typedef struct packed {
        sq_state_e state;
        sq_pol_e   first_pol;
    } sq_seq_regs_t;

endpackage

// File: rtl/squelch_tick_counter.sv
module squelch_tick_counter #(
    parameter int MAX_COUNT = 3,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (inc) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(MAX_COUNT)); // R5

endmodule

// File: rtl/squelch_sequencer.sv
module squelch_sequencer
    import squelch_pkg::*;
#(
    parameter int WIN_TICKS = 3,
    parameter int EOP_TICKS = 3,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_hit,
    input  logic             neg_hit,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             valid
);

    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_TICKS - 1);
    localparam logic [CNT_W-1:0] EOP_LAST = CNT_W'(EOP_TICKS);

    sq_seq_regs_t seq_d, seq_q;
    logic         any_hit;
    logic         back_hit;
    logic         opp_hit;

    always_comb begin
        any_hit  = pos_hit | neg_hit;
        back_hit = (seq_q.first_pol == POL_POS) ? pos_hit : neg_hit;
        opp_hit  = (seq_q.first_pol == POL_POS) ? neg_hit : pos_hit;
        seq_d    = seq_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        case (seq_q.state)
            SQ_IDLE: begin
                if (any_hit) begin
                    seq_d.state     = SQ_WAIT_OPP;
                    seq_d.first_pol = pos_hit ? POL_POS : POL_NEG;
                    cnt_clr         = 1'b1;
                end
            end
            SQ_WAIT_OPP: begin
                if (opp_hit) begin
                    seq_d.state = SQ_WAIT_BACK;
                    cnt_clr     = 1'b1;
                end else if (count == WIN_LAST) begin
                    seq_d.state = SQ_IDLE;
                    cnt_clr     = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            SQ_WAIT_BACK: begin
                if (back_hit) begin
                    seq_d.state = SQ_VALID;
                    cnt_clr     = 1'b1;
                end else if (count == WIN_LAST) begin
                    seq_d.state = SQ_IDLE;
                    cnt_clr     = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            SQ_VALID: begin
                if (any_hit) begin
                    cnt_clr = 1'b1;
                end else if (count == EOP_LAST) begin
                    seq_d.state = SQ_IDLE;
                    cnt_clr     = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                seq_d.state = SQ_IDLE;
                cnt_clr     = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SQ_IDLE, first_pol: POL_POS};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign valid = (seq_q.state == SQ_VALID);

    AST_IDLE_NOT_DIRECT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SQ_IDLE) |=> (seq_q.state != SQ_VALID)); // R1

    AST_WINDOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SQ_WAIT_OPP && count == WIN_LAST && !opp_hit)
        |=> (seq_q.state == SQ_IDLE)); // R2

    AST_VALID_FROM_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> ($past(seq_q.state) == SQ_WAIT_BACK)); // R3

    AST_ACTIVITY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (pos_hit || neg_hit)) |=> valid); // R5

endmodule

// File: rtl/squelch_qualifier.sv
module squelch_qualifier #(
    parameter int WIN_TICKS = 3,
    parameter int EOP_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_pos_i,
    input  logic below_neg_i,
    input  logic reduced_mode_i,
    output logic data_valid_o,
    output logic low_thresh_sel_o
);

    localparam int MAX_COUNT = (WIN_TICKS > EOP_TICKS) ? WIN_TICKS : EOP_TICKS;
    localparam int CNT_W     = $clog2(MAX_COUNT + 1);

    logic [CNT_W-1:0] tick_count;
    logic             tick_clr;
    logic             tick_inc;
    logic             seq_valid;

    squelch_tick_counter #(
        .MAX_COUNT(MAX_COUNT),
        .CNT_W    (CNT_W)
    ) i_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .inc  (tick_inc),
        .count(tick_count)
    );

    squelch_sequencer #(
        .WIN_TICKS(WIN_TICKS),
        .EOP_TICKS(EOP_TICKS),
        .CNT_W    (CNT_W)
    ) i_sequencer (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_hit(above_pos_i),
        .neg_hit(below_neg_i),
        .count  (tick_count),
        .cnt_clr(tick_clr),
        .cnt_inc(tick_inc),
        .valid  (seq_valid)
    );

    assign data_valid_o     = seq_valid;
    assign low_thresh_sel_o = seq_valid | reduced_mode_i;

    AST_LOW_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> low_thresh_sel_o); // R6

    AST_REDUCED_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reduced_mode_i |-> low_thresh_sel_o); // R7

    AST_EOP_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid_o) |-> (low_thresh_sel_o == reduced_mode_i)); // R8

endmodule

// File: tb/test_squelch_qualifier.sv
module test_squelch_qualifier;

    localparam int CLK_PERIOD = 10;
    localparam int W = 3;
    localparam int E = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_i = 1'b0;
    logic neg_i = 1'b0;
    logic red_i = 1'b0;
    logic valid_o;
    logic low_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    squelch_qualifier #(.WIN_TICKS(W), .EOP_TICKS(E)) i_squelch_qualifier (
        .clk             (clk),
        .rst_n           (rst_n),
        .above_pos_i     (pos_i),
        .below_neg_i     (neg_i),
        .reduced_mode_i  (red_i),
        .data_valid_o    (valid_o),
        .low_thresh_sel_o(low_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // apply one sample, let one edge take it, return a quarter period later
    task automatic cyc(input logic p, input logic n);
        pos_i = p;
        neg_i = n;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    // three pulses at 0, g1, g1+g2; first polarity fp (1 = positive)
    task automatic seq_trial(input bit fp, input int g1, input int g2, input bit red);
        bit ok;
        int len;
        logic p;
        logic n;
        logic exp_v;
        red_i = red;
        ok  = (g1 <= W) && (g2 <= W);
        len = g1 + g2 + E + 2*W + 4;
        for (int i = 0; i < len; i++) begin
            p = 1'b0;
            n = 1'b0;
            if (i == 0 || i == g1 + g2) begin
                p = fp;
                n = !fp;
            end else if (i == g1) begin
                p = !fp;
                n = fp;
            end
            cyc(p, n);
            exp_v = ok && (i >= g1 + g2) && (i <= g1 + g2 + E);
            if (!ok)
                check("R2", valid_o, 1'b0);
            else if (i == g1 + g2)
                check("R3", valid_o, 1'b1);
            else if (i > g1 + g2)
                check("R5", valid_o, exp_v);
            else
                check(fp ? "R4" : "R4n", valid_o, exp_v);
            check(red ? "R7" : "R6", low_o, red | exp_v);
        end
    endtask

    // accepted packet, then four pulses spaced gap apart
    task automatic hold_trial(input int gap);
        int last_end;
        int len;
        logic p;
        logic n;
        red_i = 1'b0;
        last_end = (gap <= E + 1) ? (2 + 4*gap + E) : (2 + E);
        len = 2 + 4*gap + 2*W + E + 4;
        for (int i = 0; i < len; i++) begin
            p = (i == 0) || (i == 2);
            n = (i == 1);
            for (int k = 1; k <= 4; k++) begin
                if (i == 2 + k*gap) begin
                    p = k[0];
                    n = !k[0];
                end
            end
            cyc(p, n);
            check("R5", valid_o, (i >= 2) && (i <= last_end));
            check("R8", low_o, (i >= 2) && (i <= last_end));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        red_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R9", valid_o, 1'b0);
        check("R9", low_o, 1'b1);
        red_i = 1'b0;
        #1;
        check("R9", low_o, 1'b0);
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        check("R9", valid_o, 1'b0);
        check("R9", low_o, 1'b0);

        // R1: lone crossings of each polarity
        for (int pol = 0; pol < 2; pol++) begin
            cyc(pol == 0, pol == 1);
            for (int i = 0; i < 2*W + 2; i++) begin
                cyc(1'b0, 1'b0);
                check("R1", valid_o, 1'b0);
            end
        end

        // sweep of window gaps, polarity and mode
        for (int red = 0; red < 2; red++)
            for (int fp = 0; fp < 2; fp++)
                for (int g1 = 1; g1 <= W + 2; g1++)
                    for (int g2 = 1; g2 <= W + 2; g2++)
                        seq_trial(fp[0], g1, g2, red[0]);

        // hold through activity, then end of packet
        for (int gap = 1; gap <= E + 2; gap++)
            hold_trial(gap);

        // R8: after end of packet a lone crossing does not revive data
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        check("R3", valid_o, 1'b1);
        for (int i = 0; i < E + 1; i++) cyc(1'b0, 1'b0);
        check("R8", valid_o, 1'b0);
        check("R8", low_o, 1'b0);
        cyc(1'b1, 1'b0);
        check("R8", valid_o, 1'b0);
        for (int i = 0; i < 2*W; i++) begin
            cyc(1'b0, 1'b0);
            check("R8", valid_o, 1'b0);
        end

        // R4: both flags high while idle, positive taken as first polarity
        cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        check("R4", valid_o, 1'b1);
        for (int i = 0; i < E + 1; i++) cyc(1'b0, 1'b0);
        check("R4", valid_o, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule